// File: doc/BRIEF.md
# Boot Selector and Flash Write Guard

This block decides where the processor starts executing after each reset and which flash addresses the running application may modify. It reads a set of non-volatile option bits: a two-bit field that places the in-system-programming (ISP) loader area, a hardware boot bit, a seven-bit lower boundary for the application-writable window, and a read-lock bit. It also takes a reset-cause code with each reset event, software writes to a soft boot-select bit, flash write requests with an address, and read requests from an external programmer.

On every reset event the block registers a boot vector. A power-up first reloads the soft boot-select bit from the inverted hardware boot bit. Any other reset keeps the bit as software left it. Each flash write request gets a registered grant or deny one cycle later. A denied write also sets a sticky violation flag, which software clears. External programmer reads are gated by the lock bit.

Top module: `boot_guard_top`

## Requirements
- R1: The ISP base follows the ISP select field. Code 2'b00 gives 0x1400, 2'b01 gives 0x1800 and 2'b10 gives 0x1C00. Code 2'b11 means no ISP area, and the base is then the flash top, 0x2000.
- R2: A reset event (`boot_req` high) with cause 2'b00 (power-up) loads `soft_bsel` with the inverse of `opt_hw_boot`. The new value is visible on the next cycle.
- R3: A reset event with cause 2'b01 (pin), 2'b10 (software) or 2'b11 (reserved, treated as pin) leaves `soft_bsel` unchanged and ignores `opt_hw_boot`.
- R4: One cycle after a reset event, `boot_isp` and `boot_vec` are registered from the updated `soft_bsel`. When `soft_bsel` is 1 and an ISP area exists, the vector is the ISP base. Otherwise the vector is 0x0000 and `boot_isp` is 0. Both outputs hold between reset events.
- R5: `sbs_wr` loads `sbs_wdata` into `soft_bsel` on the next cycle. A reset event in the same cycle takes priority over the write.
- R6: A write is granted exactly when the condition boundary*512 <= address < ISP base holds.
- R7: A boundary field of 7'h7F disables the window, so every write is denied.
- R8: If boundary*512 is at or above the ISP base, the window is empty and every write is denied.
- R9: `wr_grant` or `wr_deny` pulses for one cycle, exactly one cycle after `wr_req`. The two never pulse together, and neither pulses without a request.
- R10: `wr_viol` sets one cycle after a denied request and stays set until `viol_clr`. A clear in the same cycle as a new deny leaves it set.
- R11: `prg_rd_en` equals `prg_rd_req` when `opt_lock` is 1 and is 0 when `opt_lock` is 0.
- R12: While reset is asserted, all registered outputs and `soft_bsel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_isp_sel | input | 2 | ISP area select option |
| opt_hw_boot | input | 1 | Hardware boot option bit |
| opt_iap_bound | input | 7 | Writable window lower boundary, 512-byte units |
| opt_lock | input | 1 | 1 permits programmer reads |
| boot_req | input | 1 | Reset event strobe |
| boot_cause | input | 2 | Cause of the reset event |
| sbs_wr | input | 1 | Software write of soft boot-select |
| sbs_wdata | input | 1 | Value for soft boot-select |
| wr_req | input | 1 | Flash write request |
| wr_addr | input | 13 | Flash write byte address |
| viol_clr | input | 1 | Clears the violation flag |
| prg_rd_req | input | 1 | External programmer read request |
| soft_bsel | output | 1 | Soft boot-select bit, 1 selects ISP |
| boot_vec | output | 13 | Registered boot entry address |
| boot_isp | output | 1 | Last boot went to the ISP area |
| wr_grant | output | 1 | Write granted pulse |
| wr_deny | output | 1 | Write denied pulse |
| wr_viol | output | 1 | Sticky violation flag |
| prg_rd_en | output | 1 | Programmer read enable |

## Verification
The bench probes the window edges at boundary*512-1, boundary*512, base-1 and base. An off-by-one comparator would grant or deny one byte wrongly at one of these addresses. It also covers the all-ones boundary and a boundary above the ISP base, where a missing empty-window test would grant writes into the ISP area. Reset events of each cause are mixed with software writes to the soft bit. A design that reloaded the hardware bit on pin or software resets, or that let a same-cycle software write override a reset event, would boot the wrong image. A select code of 2'b11 with the soft bit set checks the fallback to 0x0000.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;
  typedef enum logic [1:0] {
    CAUSE_PWR = 2'b00,
    CAUSE_PIN = 2'b01,
    CAUSE_SW  = 2'b10,
    CAUSE_RSV = 2'b11
  } rst_cause_e;

  localparam logic [1:0] ISP_SEL_NONE = 2'b11;
endpackage

// File: rtl/bg_region_dec.sv
module bg_region_dec #(
  parameter int ADDR_W    = 13,
  parameter int BND_W     = 7,
  parameter int BLK_SH    = 9,
  parameter int ISP_BASE0 = 'h1400,
  parameter int ISP_STEP  = 'h400,
  localparam int BASE_W   = ADDR_W + 1
) (
  input  logic [1:0]        isp_sel,
  input  logic [BND_W-1:0]  bound,
  input  logic [ADDR_W-1:0] addr,
  output logic [BASE_W-1:0] isp_base,
  output logic              isp_present,
  output logic              wr_ok
);
  import boot_guard_pkg::*;
  localparam int CMP_W = (BND_W + BLK_SH > BASE_W) ? BND_W + BLK_SH : BASE_W;

  // Base table: entries 0..2 step upward, entry 3 is the flash top (empty ISP)
  logic [BASE_W-1:0] base_tab [4];
  for (genvar k = 0; k < 4; k++) begin : g_base
    if (k == 3) begin : g_top
      assign base_tab[k] = BASE_W'(1) << ADDR_W;
    end else begin : g_step
      assign base_tab[k] = BASE_W'(ISP_BASE0 + k * ISP_STEP);
    end
  end

  logic [CMP_W-1:0] lo_w, hi_w, ad_w;
  logic             win_empty;

  always_comb begin
    isp_present = (isp_sel != ISP_SEL_NONE);
    isp_base    = base_tab[isp_sel];
    lo_w        = CMP_W'(bound) << BLK_SH;
    hi_w        = CMP_W'(isp_base);
    ad_w        = CMP_W'(addr);
    win_empty   = (&bound) || (lo_w >= hi_w);
    wr_ok       = !win_empty && (ad_w >= lo_w) && (ad_w < hi_w);
  end
endmodule

// File: rtl/bg_boot_sel.sv
module bg_boot_sel #(
  parameter int ADDR_W  = 13,
  localparam int BASE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_boot,
  input  logic              boot_req,
  input  logic [1:0]        boot_cause,
  input  logic              sbs_wr,
  input  logic              sbs_wdata,
  input  logic [BASE_W-1:0] isp_base,
  input  logic              isp_present,
  output logic              soft_bsel,
  output logic [ADDR_W-1:0] boot_vec,
  output logic              boot_isp
);
  import boot_guard_pkg::*;

  logic              soft_d, isp_d, soft_en;
  logic [ADDR_W-1:0] vec_d;

  always_comb begin
    soft_d  = soft_bsel;
    soft_en = 1'b0;
    if (boot_req) begin
      soft_en = 1'b1;
      if (boot_cause == CAUSE_PWR) soft_d = ~hw_boot;
    end else if (sbs_wr) begin
      soft_en = 1'b1;
      soft_d  = sbs_wdata;
    end
    isp_d = soft_d & isp_present;
    vec_d = isp_d ? ADDR_W'(isp_base) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_bsel <= 1'b0;
      boot_vec  <= '0;
      boot_isp  <= 1'b0;
    end else begin
      if (soft_en)  soft_bsel <= soft_d;
      if (boot_req) begin
        boot_vec <= vec_d;
        boot_isp <= isp_d;
      end
    end
  end

  a_r2_powerup_load: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req && boot_cause == CAUSE_PWR |=> soft_bsel == !$past(hw_boot));
  a_r3_keep_soft: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req && boot_cause != CAUSE_PWR |=> $stable(soft_bsel));
  a_r4_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_req |=> $stable(boot_vec) && $stable(boot_isp));
  a_r4_no_isp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_isp |-> boot_vec == '0);
endmodule

// File: rtl/bg_write_guard.sv
module bg_write_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic wr_ok,
  input  logic viol_clr,
  output logic wr_grant,
  output logic wr_deny,
  output logic wr_viol
);
  logic gnt_d, deny_d, viol_d;

  always_comb begin
    gnt_d  = wr_req & wr_ok;
    deny_d = wr_req & ~wr_ok;
    viol_d = deny_d | (wr_viol & ~viol_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_grant <= 1'b0;
      wr_deny  <= 1'b0;
      wr_viol  <= 1'b0;
    end else begin
      wr_grant <= gnt_d;
      wr_deny  <= deny_d;
      wr_viol  <= viol_d;
    end
  end

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && wr_deny));
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> !wr_grant && !wr_deny);
  a_r9_answered: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> wr_grant || wr_deny);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_viol && !viol_clr |=> wr_viol);
  a_r10_set_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
    wr_deny |-> wr_viol);
endmodule

// File: rtl/boot_guard_top.sv
module boot_guard_top #(
  parameter int ADDR_W    = 13,
  parameter int BND_W     = 7,
  parameter int BLK_SH    = 9,
  parameter int ISP_BASE0 = 'h1400,
  parameter int ISP_STEP  = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        opt_isp_sel,
  input  logic              opt_hw_boot,
  input  logic [BND_W-1:0]  opt_iap_bound,
  input  logic              opt_lock,
  input  logic              boot_req,
  input  logic [1:0]        boot_cause,
  input  logic              sbs_wr,
  input  logic              sbs_wdata,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              viol_clr,
  input  logic              prg_rd_req,
  output logic              soft_bsel,
  output logic [ADDR_W-1:0] boot_vec,
  output logic              boot_isp,
  output logic              wr_grant,
  output logic              wr_deny,
  output logic              wr_viol,
  output logic              prg_rd_en
);
  localparam int BASE_W = ADDR_W + 1;

  // Reset: asserted asynchronously, released through two flops
  logic rs_q1, rs_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  logic [BASE_W-1:0] isp_base;
  logic              isp_present, wr_ok;

  bg_region_dec #(
    .ADDR_W(ADDR_W), .BND_W(BND_W), .BLK_SH(BLK_SH),
    .ISP_BASE0(ISP_BASE0), .ISP_STEP(ISP_STEP)
  ) u_dec (
    .isp_sel(opt_isp_sel), .bound(opt_iap_bound), .addr(wr_addr),
    .isp_base(isp_base), .isp_present(isp_present), .wr_ok(wr_ok)
  );

  bg_boot_sel #(.ADDR_W(ADDR_W)) u_boot (
    .clk(clk), .rst_n(rs_q2), .hw_boot(opt_hw_boot),
    .boot_req(boot_req), .boot_cause(boot_cause),
    .sbs_wr(sbs_wr), .sbs_wdata(sbs_wdata),
    .isp_base(isp_base), .isp_present(isp_present),
    .soft_bsel(soft_bsel), .boot_vec(boot_vec), .boot_isp(boot_isp)
  );

  bg_write_guard u_guard (
    .clk(clk), .rst_n(rs_q2), .wr_req(wr_req), .wr_ok(wr_ok),
    .viol_clr(viol_clr), .wr_grant(wr_grant), .wr_deny(wr_deny),
    .wr_viol(wr_viol)
  );

  assign prg_rd_en = prg_rd_req & opt_lock;

  a_r7_no_window: assert property (@(posedge clk) disable iff (!rs_q2)
    wr_req && (&opt_iap_bound) |=> !wr_grant);
  a_r11_locked: assert property (@(posedge clk) disable iff (!rs_q2)
    !opt_lock |-> !prg_rd_en);
  a_r6_grant_below_base: assert property (@(posedge clk) disable iff (!rs_q2)
    wr_req && ({1'b0, wr_addr} >= isp_base) |=> wr_deny);
endmodule

// File: tb/tb_boot_guard_top.sv
module tb_boot_guard_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  opt_isp_sel;
  logic        opt_hw_boot;
  logic [6:0]  opt_iap_bound;
  logic        opt_lock;
  logic        boot_req;
  logic [1:0]  boot_cause;
  logic        sbs_wr, sbs_wdata, wr_req, viol_clr, prg_rd_req;
  logic [12:0] wr_addr;
  logic        soft_bsel, boot_isp, wr_grant, wr_deny, wr_viol, prg_rd_en;
  logic [12:0] boot_vec;

  boot_guard_top dut (.*);

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  // reference state
  int m_soft = 0, m_vec = 0, m_isp = 0, m_gnt = 0, m_deny = 0, m_viol = 0;

  task automatic chk(string rq, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int base_of(int sel);
    if (sel == 3) return 8192;
    return 5120 + sel * 1024;   // R1 encodings
  endfunction

  function automatic int may_write(int bnd, int sel, int a);
    int lo, hi;
    lo = bnd * 512;
    hi = base_of(sel);
    if (bnd == 127) return 0;    // R7
    if (lo >= hi) return 0;      // R8
    return (a >= lo && a < hi) ? 1 : 0;  // R6
  endfunction

  task automatic idle();
    boot_req = 0; boot_cause = 0; sbs_wr = 0; sbs_wdata = 0;
    wr_req = 0; wr_addr = 0; viol_clr = 0; prg_rd_req = 0;
  endtask

  task automatic compare_regs();
    chk("R2/R3/R5 soft_bsel", soft_bsel, m_soft);
    chk("R4 boot_vec", boot_vec, m_vec);
    chk("R4 boot_isp", boot_isp, m_isp);
    chk("R9 wr_grant", wr_grant, m_gnt);
    chk("R9 wr_deny", wr_deny, m_deny);
    chk("R10 wr_viol", wr_viol, m_viol);
  endtask

  // advance the reference by one clock using the inputs now applied
  task automatic model_step();
    int g, sel;
    if (boot_req) begin
      if (boot_cause == 0) m_soft = opt_hw_boot ? 0 : 1;
      sel   = m_soft;
      m_isp = (sel == 1 && opt_isp_sel != 3) ? 1 : 0;
      m_vec = m_isp ? base_of(opt_isp_sel) : 0;
    end else if (sbs_wr) begin
      m_soft = sbs_wdata;
    end
    g = may_write(opt_iap_bound, opt_isp_sel, wr_addr);
    m_gnt  = (wr_req && g) ? 1 : 0;
    m_deny = (wr_req && !g) ? 1 : 0;
    if (m_deny) m_viol = 1;
    else if (viol_clr) m_viol = 0;
  endtask

  task automatic pick_addr();
    int lo, hi, r;
    lo = opt_iap_bound * 512;
    hi = base_of(opt_isp_sel);
    r = $urandom % 5;
    case (r)
      0: wr_addr = 13'(lo - 1);
      1: wr_addr = 13'(lo);
      2: wr_addr = 13'(hi - 1);
      3: wr_addr = 13'(hi);
      default: wr_addr = 13'($urandom);
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    idle();
    opt_isp_sel = 2'b11; opt_hw_boot = 1; opt_iap_bound = 7'h7F; opt_lock = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare_regs();   // R12 reset state
    chk("R12 soft_bsel at reset", soft_bsel, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare_regs();

    for (int cfg = 0; cfg < 48; cfg++) begin
      case (cfg)
        0: begin opt_isp_sel = 0; opt_iap_bound = 7'd4;  opt_hw_boot = 0; opt_lock = 0; end
        1: begin opt_isp_sel = 1; opt_iap_bound = 7'd0;  opt_hw_boot = 1; opt_lock = 1; end
        2: begin opt_isp_sel = 2; opt_iap_bound = 7'h7F; opt_hw_boot = 0; opt_lock = 1; end
        3: begin opt_isp_sel = 0; opt_iap_bound = 7'd12; opt_hw_boot = 0; opt_lock = 0; end
        4: begin opt_isp_sel = 3; opt_iap_bound = 7'd8;  opt_hw_boot = 0; opt_lock = 1; end
        5: begin opt_isp_sel = 3; opt_iap_bound = 7'd16; opt_hw_boot = 1; opt_lock = 1; end
        6: begin opt_isp_sel = 2; opt_iap_bound = 7'd14; opt_hw_boot = 0; opt_lock = 1; end
        default: begin
          opt_isp_sel   = 2'($urandom);
          opt_iap_bound = ($urandom % 4 == 0) ? 7'h7F : 7'($urandom % 18);
          opt_hw_boot   = 1'($urandom);
          opt_lock      = 1'($urandom);
        end
      endcase
      for (int cyc = 0; cyc < 30; cyc++) begin
        idle();
        boot_req   = ($urandom % 5 == 0);
        boot_cause = 2'($urandom);
        sbs_wr     = ($urandom % 4 == 0);
        sbs_wdata  = 1'($urandom);
        wr_req     = ($urandom % 2 == 0);
        pick_addr();
        viol_clr   = ($urandom % 6 == 0);
        prg_rd_req = 1'($urandom);
        #1;
        chk("R11 prg_rd_en", prg_rd_en, (prg_rd_req && opt_lock) ? 1 : 0);
        model_step();
        @(negedge clk);
        compare_regs();   // R1 R4 R6 R7 R8 R9 R10 via reference
      end
    end

    idle();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule